// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Access Port

This block is the byte-wide host side of a two-channel serial controller. The host sees four byte addresses. One address bit picks the channel and the other picks control or data access. Data accesses are passed to the selected channel as one-cycle strobes. Control accesses reach a bank of sixteen write registers and sixteen read registers per channel, but only through a register pointer. A first control write, made while the pointer is zero, loads the pointer. The next control access then reaches the register the pointer names. After that access the pointer falls back to zero.

Register 9 carries a reset field that the block decodes itself. It can reset one channel in the soft way, or reset both channels in the hard way. Each kind of reset forces some bits, keeps some bits and clears others in a set of registers. The serializer, baud generation and interrupt logic are not part of this block. They take their settings from the write-register output bus.

Top module: `dualchan_regport`

## Requirements
- R1: `addr[0]` = 0 selects a control access and 1 selects a data access. `addr[1]` = 0 selects channel B (index 0) and 1 selects channel A (index 1). Write register r of channel c appears on `wregs[(c*16+r)*8 +: 8]`.
- R2: A control write made while a channel's pointer is 0 loads the pointer with `wdata[2:0]`. If `wdata[5:3]` equals 3'b001, 8 is added to the pointer. Any other command code leaves only `wdata[2:0]` in the pointer.
- R3: A control write to a non-zero pointer returns that pointer to 0, and so does any control read. A control read puts the read register named by the pointer on `rdata` one cycle later.
- R4: A control write to a register with no special handling stores the byte unchanged. This applies to registers 4, 10, 11, 14 and 15.
- R5: A soft reset of a channel does all of the following:
  - clears bit 0 of write register 3 and sets bit 2 of write register 4;
  - keeps only bits 6:5 of write register 10 and sets bit 5 of write register 14;
  - sets write register 15 to 0xF8;
  - keeps only bits 7, 5, 4 and 3 of read register 0 and then sets bits 6 and 2;
  - keeps only bit 0 of read register 1 and then sets bits 2:1;
  - returns the channel's pointer to 0.
- R6: A hard reset applies the soft reset to both channels and then sets the following write registers:
  - register 9 keeps bits 1:0 and has 0xC0 set;
  - register 10 becomes 0x00;
  - register 11 becomes 0x08;
  - register 14 keeps bits 7:6 and has 0x30 set.
- R7: A control write to register 12 or 13 is stored in the write register and is also copied into the read register of the same number.
- R8: A control write to register 3 with bit 4 set also sets bit 4 of read register 0.
- R9: After `rst_n` is low at a clock edge, every register and pointer is zero, except that bit 2 of read register 0 is 1 in both channels.
- R10: A data write pulses `data_wr_stb[c]` and a data read pulses `data_rd_stb[c]` for one cycle. A data read returns `rx_data[c*8 +: 8]` on `rdata` one cycle later. Data accesses do not move the pointer. If `wr_en` and `rd_en` are both high, the write is performed.
- R11: A write to register 9 acts on the code in `wdata[7:6]`, whichever channel is addressed:
  - 01 soft-resets channel B;
  - 10 soft-resets channel A;
  - 11 hard-resets both channels.
  A non-zero code does not store the byte. Code 00 stores the byte in the addressed channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Bit 0: 0 control, 1 data; bit 1: 0 channel B, 1 channel A |
| wr_en | input | 1 | Write access this cycle |
| rd_en | input | 1 | Read access this cycle |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid the cycle after a read |
| rx_data | input | 16 | Received byte per channel, channel c at bits c*8+7:c*8 |
| data_wr_stb | output | 2 | Per-channel data write strobe |
| data_rd_stb | output | 2 | Per-channel data read strobe |
| wregs | output | 256 | All write registers of both channels |

## Verification
The hardest case to reach is a reset aimed at one channel while that channel sits partway through a two-step access with a non-zero pointer parked. From the ports, this needs a pointer load on the target channel first. Then a register-9 reset command must be sent through the other channel, and only after that the target channel is read. The stimulus sets up that sequence, with non-default values already written into every register a reset touches. Each keep mask and each force mask therefore shows up as a distinct byte. A hard reset is then issued through the opposite channel to check both banks at once.

// File: rtl/regport_pkg.sv
// Package: shared types, register indices and the reset value functions
// for the dual-channel register access port.
// Assumes 8-bit registers and 16 registers per direction per channel.
package regport_pkg;

    localparam int REG_BITS  = 8;
    localparam int REG_COUNT = 16;
    localparam int PTR_BITS  = $clog2(REG_COUNT);
    localparam int CHANNELS  = 2;

    typedef logic [REG_COUNT-1:0][REG_BITS-1:0] regbank_t;

    // Register indices whose behaviour is decoded by this block
    localparam logic [PTR_BITS-1:0] IDX_PTRCMD  = 4'd0;
    localparam logic [PTR_BITS-1:0] IDX_RXCFG   = 4'd3;
    localparam logic [PTR_BITS-1:0] IDX_FRAME   = 4'd4;
    localparam logic [PTR_BITS-1:0] IDX_MASTER  = 4'd9;
    localparam logic [PTR_BITS-1:0] IDX_LINECFG = 4'd10;
    localparam logic [PTR_BITS-1:0] IDX_CLKSRC  = 4'd11;
    localparam logic [PTR_BITS-1:0] IDX_DIVLO   = 4'd12;
    localparam logic [PTR_BITS-1:0] IDX_DIVHI   = 4'd13;
    localparam logic [PTR_BITS-1:0] IDX_AUX     = 4'd14;
    localparam logic [PTR_BITS-1:0] IDX_EVTEN   = 4'd15;
    localparam logic [PTR_BITS-1:0] IDX_STAT    = 4'd0;
    localparam logic [PTR_BITS-1:0] IDX_STAT2   = 4'd1;

    // Reset field codes in register 9 bits 7:6
    typedef enum logic [1:0] {
        RST_NONE = 2'b00,
        RST_CHB  = 2'b01,
        RST_CHA  = 2'b10,
        RST_BOTH = 2'b11
    } rst_code_e;

    localparam logic [2:0] CMD_POINT_HIGH = 3'b001;
    localparam int         HUNT_BIT       = 4;
    localparam logic [7:0] STAT_POWERON   = 8'h04;

    // Soft reset of the write bank
    function automatic regbank_t soft_wbank(regbank_t w);
        regbank_t n = w;
        n[IDX_RXCFG]   = w[IDX_RXCFG] & 8'hFE;
        n[IDX_FRAME]   = w[IDX_FRAME] | 8'h04;
        n[IDX_LINECFG] = w[IDX_LINECFG] & 8'h60;
        n[IDX_AUX]     = w[IDX_AUX] | 8'h20;
        n[IDX_EVTEN]   = 8'hF8;
        return n;
    endfunction

    // Hard reset of the write bank: soft reset then extra forcing
    function automatic regbank_t hard_wbank(regbank_t w);
        regbank_t n = soft_wbank(w);
        n[IDX_MASTER]  = (w[IDX_MASTER] & 8'h03) | 8'hC0;
        n[IDX_LINECFG] = 8'h00;
        n[IDX_CLKSRC]  = 8'h08;
        n[IDX_AUX]     = (n[IDX_AUX] & 8'hC0) | 8'h30;
        return n;
    endfunction

    // Soft or hard reset of the read bank (identical for both)
    function automatic regbank_t soft_rbank(regbank_t r);
        regbank_t n = r;
        n[IDX_STAT]  = (r[IDX_STAT] & 8'hB8) | 8'h44;
        n[IDX_STAT2] = (r[IDX_STAT2] & 8'h01) | 8'h06;
        return n;
    endfunction

endpackage

// File: rtl/regport_decode.sv
// Module: address and strobe decoder.
// Splits one host access into a per-channel control write/read or data
// write/read strobe. Assumes at most one access per cycle; a write wins
// over a simultaneous read.
module regport_decode
    import regport_pkg::*;
#(
    parameter int NCH = CHANNELS
) (
    input  logic [1:0]     addr,
    input  logic           wr_en,
    input  logic           rd_en,
    output logic [NCH-1:0] ctl_wr,
    output logic [NCH-1:0] ctl_rd,
    output logic [NCH-1:0] dat_wr,
    output logic [NCH-1:0] dat_rd,
    output logic           sel_ch
);
    logic is_data;
    logic do_rd;

    // Access kind and channel from the address bits
    always_comb begin
        is_data = addr[0];
        sel_ch  = addr[1];
        do_rd   = rd_en && !wr_en;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        // Per-channel strobe generation
        always_comb begin
            hit       = (sel_ch == c[0]);
            ctl_wr[c] = hit && wr_en && !is_data;
            ctl_rd[c] = hit && do_rd && !is_data;
            dat_wr[c] = hit && wr_en && is_data;
            dat_rd[c] = hit && do_rd && is_data;
        end
    end
endmodule

// File: rtl/regport_chan.sv
// Module: one channel's register pointer and register banks.
// Holds the pointer, 16 write and 16 read registers, applies the pointer
// command, the mirrored and side-effect writes, and the reset values.
// Assumes soft_rst/hard_rst come from the top's reset decode and that
// ctl_wr and ctl_rd are never high together.
module regport_chan
    import regport_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic                ctl_rd,
    input  logic [REG_BITS-1:0] wdata,
    input  logic                soft_rst,
    input  logic                hard_rst,
    output logic [REG_BITS-1:0] rd_byte,
    output logic [1:0]          rst_cmd,
    output regbank_t            wbank_o
);
    regbank_t            wbank;
    regbank_t            rbank;
    logic [PTR_BITS-1:0] ptr;

    // Read register currently addressed and reset request from register 9
    always_comb begin
        rd_byte = rbank[ptr];
        rst_cmd = (ctl_wr && ptr == IDX_MASTER) ? wdata[7:6] : RST_NONE;
        wbank_o = wbank;
    end

    // Pointer, register banks and reset application
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbank           <= '0;
            rbank           <= '0;
            rbank[IDX_STAT] <= STAT_POWERON;
            ptr             <= '0;
        end else if (hard_rst) begin
            wbank <= hard_wbank(wbank);
            rbank <= soft_rbank(rbank);
            ptr   <= '0;
        end else if (soft_rst) begin
            wbank <= soft_wbank(wbank);
            rbank <= soft_rbank(rbank);
            ptr   <= '0;
        end else if (ctl_wr) begin
            if (ptr == IDX_PTRCMD) begin
                ptr <= {wdata[5:3] == CMD_POINT_HIGH, wdata[2:0]};
            end else begin
                ptr <= '0;
                case (ptr)
                    IDX_MASTER: begin
                        if (wdata[7:6] == RST_NONE) wbank[IDX_MASTER] <= wdata;
                    end
                    IDX_RXCFG: begin
                        wbank[IDX_RXCFG] <= wdata;
                        if (wdata[HUNT_BIT]) rbank[IDX_STAT][HUNT_BIT] <= 1'b1;
                    end
                    IDX_DIVLO, IDX_DIVHI: begin
                        wbank[ptr] <= wdata;
                        rbank[ptr] <= wdata;
                    end
                    default: wbank[ptr] <= wdata;
                endcase
            end
        end else if (ctl_rd) begin
            ptr <= '0;
        end
    end

    AST_PTR_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd |=> ptr == '0); // R3
    AST_PTR_CLEAR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ptr != '0) |=> ptr == '0); // R3
    AST_PTR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && !ctl_rd && !soft_rst && !hard_rst) |=> $stable(ptr)); // R10
    AST_SOFT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst || hard_rst) |=> (rbank[IDX_STAT][2] && rbank[IDX_STAT][6]
                                    && rbank[IDX_STAT2][2:1] == 2'b11)); // R5
    AST_SOFT_EVTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst || hard_rst) |=> wbank[IDX_EVTEN] == 8'hF8); // R5
    AST_HARD_CLKSRC: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst |=> (wbank[IDX_CLKSRC] == 8'h08 && wbank[IDX_LINECFG] == 8'h00)); // R6
    AST_DIV_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !soft_rst && !hard_rst && (ptr == IDX_DIVLO || ptr == IDX_DIVHI))
        |=> rbank[$past(ptr)] == $past(wdata)); // R7
    AST_HUNT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !soft_rst && !hard_rst && ptr == IDX_RXCFG && wdata[HUNT_BIT])
        |=> rbank[IDX_STAT][HUNT_BIT]); // R8
    AST_RST_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !hard_rst && ptr == IDX_MASTER && wdata[7:6] != RST_NONE)
        |=> $stable(wbank[IDX_MASTER])); // R11
endmodule

// File: rtl/dualchan_regport.sv
// Module: top of the dual-channel register access port.
// Decodes the host access, routes it to the two channel register blocks,
// combines the register-9 reset requests and registers the read byte.
// Assumes one host access per cycle; channel index 0 is channel B.
module dualchan_regport
    import regport_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   addr,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    input  logic [15:0]  rx_data,
    output logic [1:0]   data_wr_stb,
    output logic [1:0]   data_rd_stb,
    output logic [255:0] wregs
);
    localparam int BANK_BITS = REG_COUNT * REG_BITS;

    logic [CHANNELS-1:0] ctl_wr, ctl_rd, dat_wr, dat_rd;
    logic                sel_ch;
    logic [1:0]          rst_cmd [CHANNELS];
    logic [7:0]          rd_byte [CHANNELS];
    logic [CHANNELS-1:0] soft_rst;
    logic                hard_rst;

    regport_decode #(.NCH(CHANNELS)) u_decode (
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .ctl_wr (ctl_wr),
        .ctl_rd (ctl_rd),
        .dat_wr (dat_wr),
        .dat_rd (dat_rd),
        .sel_ch (sel_ch)
    );

    // Combine reset requests from either channel into per-channel resets
    always_comb begin
        hard_rst    = 1'b0;
        soft_rst    = '0;
        for (int c = 0; c < CHANNELS; c++) begin
            hard_rst    = hard_rst    || (rst_cmd[c] == RST_BOTH);
            soft_rst[0] = soft_rst[0] || (rst_cmd[c] == RST_CHB);
            soft_rst[1] = soft_rst[1] || (rst_cmd[c] == RST_CHA);
        end
        data_wr_stb = dat_wr;
        data_rd_stb = dat_rd;
    end

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        regbank_t wbank;
        regport_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_wr   (ctl_wr[c]),
            .ctl_rd   (ctl_rd[c]),
            .wdata    (wdata),
            .soft_rst (soft_rst[c]),
            .hard_rst (hard_rst),
            .rd_byte  (rd_byte[c]),
            .rst_cmd  (rst_cmd[c]),
            .wbank_o  (wbank)
        );
        assign wregs[c*BANK_BITS +: BANK_BITS] = wbank;
    end

    // Registered read byte from the control or data path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (|ctl_rd) begin
            rdata <= rd_byte[sel_ch];
        end else if (|dat_rd) begin
            rdata <= rx_data[sel_ch*8 +: 8];
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_wr, ctl_rd, data_wr_stb, data_rd_stb})); // R10
    AST_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (|data_rd_stb) |=> rdata == $past(rx_data[sel_ch*8 +: 8])); // R10
    AST_RESET_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(hard_rst && |soft_rst)); // R11
endmodule

// File: tb/dualchan_regport_bench.sv
module dualchan_regport_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   addr;
    logic         wr_en, rd_en;
    logic [7:0]   wdata;
    logic [7:0]   rdata;
    logic [15:0]  rx_data;
    logic [1:0]   data_wr_stb, data_rd_stb;
    logic [255:0] wregs;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic rd_pend = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    localparam bit CH_B = 1'b0;
    localparam bit CH_A = 1'b1;

    dualchan_regport u_dualchan_regport (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_data(rx_data),
        .data_wr_stb(data_wr_stb), .data_rd_stb(data_rd_stb), .wregs(wregs)
    );

    always #10 clk = ~clk;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        rd_pend <= rd_en;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: act=%0d cycles exp=<20000", cycles);
            report();
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    // Monitor: compares each read result with the scoreboard entry
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: act=%02h exp=<none>", rdata);
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    function automatic logic [7:0] wr(bit ch, int r);
        return wregs[(int'(ch)*16 + r)*8 +: 8];
    endfunction

    task automatic ctl_write(bit ch, logic [7:0] v);
        @(negedge clk);
        addr = {ch, 1'b0}; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_write(bit ch, logic [7:0] ptrbyte, logic [7:0] v);
        ctl_write(ch, ptrbyte);
        ctl_write(ch, v);
    endtask

    // Driver: pushes the expected byte, then performs the read
    task automatic ctl_read(bit ch, logic [7:0] exp, string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        addr = {ch, 1'b0}; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
        rx_data = 16'h3CC3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 power-on state
        chk("R9 wregs zero B", wr(CH_B, 4), 8'h00);
        chk("R9 wregs zero A", wr(CH_A, 15), 8'h00);
        ctl_read(CH_B, 8'h04, "R9 status B");
        ctl_read(CH_A, 8'h04, "R9 status A");

        // R4 plain store, R3 pointer back to 0 after write
        reg_write(CH_B, 8'h04, 8'h41);
        chk("R4 reg4 B", wr(CH_B, 4), 8'h41);
        chk("R1 channel A untouched", wr(CH_A, 4), 8'h00);
        ctl_read(CH_B, 8'h04, "R3 ptr zero after write");

        // R2 point-high, R7 mirror
        reg_write(CH_B, 8'h0C, 8'h34);
        chk("R7 wr12 B", wr(CH_B, 12), 8'h34);
        ctl_write(CH_B, 8'h0C);
        ctl_read(CH_B, 8'h34, "R7 rd12 B");
        reg_write(CH_B, 8'h0D, 8'h12);
        ctl_write(CH_B, 8'h0D);
        ctl_read(CH_B, 8'h12, "R7 rd13 B");
        ctl_read(CH_B, 8'h04, "R3 ptr zero after read");

        // R8 hunt bit
        reg_write(CH_A, 8'h03, 8'h11);
        chk("R8 wr3 A", wr(CH_A, 3), 8'h11);
        ctl_read(CH_A, 8'h14, "R8 sync in status A");

        // R2 other command code keeps only bits 2:0
        reg_write(CH_B, 8'h2B, 8'h45);
        chk("R2 cmd 101 ptr 3", wr(CH_B, 3), 8'h45);
        chk("R2 reg11 untouched", wr(CH_B, 11), 8'h00);

        // R4 more plain registers, R11 store with code 00
        reg_write(CH_B, 8'h0A, 8'h7F);
        reg_write(CH_B, 8'h0E, 8'h5A);
        reg_write(CH_B, 8'h09, 8'h02);
        chk("R4 reg10 B", wr(CH_B, 10), 8'h7F);
        chk("R4 reg14 B", wr(CH_B, 14), 8'h5A);
        chk("R11 reg9 code00 stored", wr(CH_B, 9), 8'h02);

        // R5 soft reset of B through A with B pointer parked at 5
        ctl_write(CH_B, 8'h05);
        reg_write(CH_A, 8'h09, 8'h40);
        chk("R11 reg9 A not stored", wr(CH_A, 9), 8'h00);
        chk("R5 wr3 B", wr(CH_B, 3), 8'h44);
        chk("R5 wr4 B", wr(CH_B, 4), 8'h45);
        chk("R5 wr10 B", wr(CH_B, 10), 8'h60);
        chk("R5 wr14 B", wr(CH_B, 14), 8'h7A);
        chk("R5 wr15 B", wr(CH_B, 15), 8'hF8);
        chk("R5 wr12 B kept", wr(CH_B, 12), 8'h34);
        chk("R5 wr9 B kept", wr(CH_B, 9), 8'h02);
        chk("R11 channel A not reset", wr(CH_A, 3), 8'h11);
        ctl_read(CH_B, 8'h44, "R5 status B, pointer cleared");
        ctl_write(CH_B, 8'h01);
        ctl_read(CH_B, 8'h06, "R5 rd1 B");
        ctl_write(CH_B, 8'h0C);
        ctl_read(CH_B, 8'h34, "R5 rd12 B kept");

        // R6 hard reset of both through B
        reg_write(CH_A, 8'h09, 8'h03);
        reg_write(CH_A, 8'h0A, 8'h22);
        reg_write(CH_A, 8'h0B, 8'h99);
        reg_write(CH_A, 8'h0E, 8'h83);
        reg_write(CH_B, 8'h09, 8'hC0);
        chk("R6 wr9 A", wr(CH_A, 9), 8'hC3);
        chk("R6 wr10 A", wr(CH_A, 10), 8'h00);
        chk("R6 wr11 A", wr(CH_A, 11), 8'h08);
        chk("R6 wr14 A", wr(CH_A, 14), 8'hB0);
        chk("R6 wr15 A", wr(CH_A, 15), 8'hF8);
        chk("R6 wr3 A", wr(CH_A, 3), 8'h10);
        chk("R6 wr9 B", wr(CH_B, 9), 8'hC2);
        chk("R6 wr14 B", wr(CH_B, 14), 8'h70);
        chk("R6 wr11 B", wr(CH_B, 11), 8'h08);
        ctl_read(CH_A, 8'h54, "R6 status A");
        ctl_read(CH_B, 8'h44, "R6 status B");

        // R10 data strobes, data read, pointer untouched
        ctl_write(CH_A, 8'h04);
        @(negedge clk);
        addr = {CH_B, 1'b1}; wdata = 8'hA5; wr_en = 1'b1;
        #1 chk("R10 data write strobe B", {6'd0, data_wr_stb}, 8'h01);
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk("R10 strobe one cycle", {6'd0, data_wr_stb}, 8'h00);
        exp_q.push_back(8'h3C); tag_q.push_back("R10 data read A");
        @(negedge clk);
        addr = {CH_A, 1'b1}; rd_en = 1'b1;
        #1 chk("R10 data read strobe A", {6'd0, data_rd_stb}, 8'h02);
        @(negedge clk);
        rd_en = 1'b0;
        ctl_write(CH_A, 8'h99);
        chk("R10 pointer kept over data access", wr(CH_A, 4), 8'h99);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: act=%0d pending exp=0", exp_q.size());
        end
        report();
    end
endmodule